// File: doc/BRIEF.md
# Second-Level Event Buffer Throttle

This block tracks how many first-level-accepted events wait in a second-level event store while the second-level trigger decides their fate. Each stored event is one 36-word slot: 4 tag words and then 32 data words. The block counts how many slots are in use. Decisions come as accept or reject and always apply to the oldest stored event. A reject frees that event. An accept frees it and moves it into an output derandomizer, which the downstream reader empties one event at a time with a drain strobe.

Two throttles guard the two stores. Each one has a nearly-full threshold and a release point a fixed hysteresis below it. Either throttle raises a single throttle line back to the first-level trigger. Decisions closer together than one event readout time (36 cycles) are flagged. So are decisions that arrive when the store is empty, and every overflow of either store. All four flags stay set until a synchronous reset.

The interface has no valid/ready handshake. Back-pressure works through the throttle line alone. The upstream side must stop sending events while throttle is high. The block never refuses a strobe. A strobe that would overflow a store is reported on a flag instead, and the count holds at the store's capacity.

Top module: `l2buf_throttle`

## Requirements
- R1: A synchronous active-high reset sets both occupancy counts to 0, drives throttle low and clears all four error flags.
- R2: Each cycle with evt_wr high adds one event to buf_count. A write and an applied decision in the same cycle leave buf_count unchanged.
- R3: An applied decision retires the oldest event. With dec_accept=1 (accept), buf_count falls by one and out_count rises by one. With dec_accept=0 (reject), buf_count falls by one and out_count is unchanged.
- R4: Each cycle with drain high removes one event from out_count. A drain with out_count at 0 is ignored.
- R5: A decision that arrives fewer than 36 cycles after the previous applied decision sets gap_err, and that decision is still applied. A decision exactly 36 cycles later is legal. The first decision after reset is always legal.
- R6: A decision that arrives while buf_count is 0 sets udf_err. It changes neither count and does not restart the 36-cycle spacing window.
- R7: The event-store throttle turns on when buf_count reaches 990. Once on, it stays on until buf_count falls to 982 or below.
- R8: The output-store throttle turns on when out_count reaches 14 (depth 16 minus 2). Once on, it stays on until out_count falls to 6 or below. The throttle output is the OR of the R7 and R8 conditions.
- R9: A write while buf_count is 1000, with no decision applied in the same cycle, sets buf_ovf. buf_count stays at 1000.
- R10: An accept while out_count is 16, with no drain in the same cycle, sets out_ovf. out_count stays at 16, and the event still leaves the event store.
- R11: buf_ovf, out_ovf, gap_err and udf_err stay set once raised, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_wr | input | 1 | One event has been written into the event store |
| dec_valid | input | 1 | Second-level decision present this cycle |
| dec_accept | input | 1 | Decision value: 1 accept, 0 reject |
| drain | input | 1 | One event read out of the output store |
| buf_count | output | 10 | Events held in the event store |
| out_count | output | 5 | Events held in the output store |
| throttle | output | 1 | Block first-level triggers |
| buf_ovf | output | 1 | Sticky: event store overflow |
| out_ovf | output | 1 | Sticky: output store overflow |
| gap_err | output | 1 | Sticky: decision spacing violated |
| udf_err | output | 1 | Sticky: decision with empty event store |

## Verification
Both occupancy counts are registered and appear directly on the ports. A corrupted count is therefore visible one cycle after the strobe that caused it. Once a count is wrong, the throttle edge moves too: it appears at the wrong write or stays on past the release point.

A spacing timer that is off by one shows up only on the next decision. That decision raises gap_err at 36 cycles, or fails to raise it at 35. The bench therefore places decisions on both sides of that boundary. A lost hysteresis state bit shows up when a store drains past the high threshold. In that case throttle drops at once instead of holding until the release point.

// File: rtl/l2buf_pkg.sv
package l2buf_pkg;

  // Sticky error vector kept by the top level.
  typedef struct packed {
    logic buf_ovf;
    logic out_ovf;
    logic gap_err;
    logic udf_err;
  } err_flags_t;

  // How a single cycle's decision input is classified.
  typedef enum logic [1:0] {
    DEC_NONE   = 2'd0,
    DEC_REJECT = 2'd1,
    DEC_ACCEPT = 2'd2,
    DEC_EMPTY  = 2'd3
  } dec_kind_e;

endpackage

// File: rtl/l2b_occ_counter.sv
// Saturating occupancy counter with an overflow pulse.
module l2b_occ_counter #(
  parameter int DEPTH = 16,
  parameter int W     = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] FULL_V = W'(DEPTH);

  logic [W-1:0] cnt_q, cnt_d;
  logic         full, empty, eff_inc, eff_dec;

  assign full  = (cnt_q == FULL_V);
  assign empty = (cnt_q == '0);

  always_comb begin
    eff_dec = dec_i & ~empty;
    eff_inc = inc_i & (~full | eff_dec);
    ovf_o   = inc_i & full & ~eff_dec;
    cnt_d   = cnt_q;
    if (eff_inc && !eff_dec)
      cnt_d = cnt_q + W'(1);
    else if (eff_dec && !eff_inc)
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/l2b_hyst_throttle.sv
// Nearly-full detector with a release point below the trip point.
module l2b_hyst_throttle #(
  parameter int W  = 5,
  parameter int HI = 14,
  parameter int LO = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_i,
  output logic         thr_o
);

  localparam logic [W-1:0] HI_V = W'(HI);
  localparam logic [W-1:0] LO_V = W'(LO);

  logic hot_q;

  assign thr_o = (cnt_i >= HI_V) || (hot_q && (cnt_i > LO_V));

  always_ff @(posedge clk) begin
    if (rst) hot_q <= 1'b0;
    else     hot_q <= thr_o;
  end

endmodule

// File: rtl/l2b_dec_spacer.sv
// Tracks cycles since the last applied decision, saturating at MIN_GAP.
module l2b_dec_spacer #(
  parameter int MIN_GAP = 36,
  parameter int GW      = $clog2(MIN_GAP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  output logic ready_o
);

  localparam logic [GW-1:0] SAT_V = GW'(MIN_GAP);

  logic [GW-1:0] gap_q;

  assign ready_o = (gap_q == SAT_V);

  always_ff @(posedge clk) begin
    if (rst)
      gap_q <= SAT_V;
    else if (take_i)
      gap_q <= GW'(1);
    else if (gap_q != SAT_V)
      gap_q <= gap_q + GW'(1);
  end

endmodule

// File: rtl/l2buf_throttle.sv
module l2buf_throttle
  import l2buf_pkg::*;
#(
  parameter int BUF_DEPTH  = 1000,
  parameter int BUF_HI     = 990,
  parameter int OUT_DEPTH  = 16,
  parameter int OUT_HI     = OUT_DEPTH - 2,
  parameter int HYST       = 8,
  parameter int TAG_WORDS  = 4,
  parameter int DATA_WORDS = 32,
  localparam int BW        = $clog2(BUF_DEPTH + 1),
  localparam int OW        = $clog2(OUT_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_wr,
  input  logic          dec_valid,
  input  logic          dec_accept,
  input  logic          drain,
  output logic [BW-1:0] buf_count,
  output logic [OW-1:0] out_count,
  output logic          throttle,
  output logic          buf_ovf,
  output logic          out_ovf,
  output logic          gap_err,
  output logic          udf_err
);

  localparam int MIN_GAP = TAG_WORDS + DATA_WORDS;
  localparam int BUF_LO  = BUF_HI - HYST;
  localparam int OUT_LO  = OUT_HI - HYST;

  dec_kind_e  kind;
  logic       take, gap_ready, buf_ovf_p, out_ovf_p, thr_buf, thr_out;
  err_flags_t err_q, err_set;

  // Classify this cycle's decision against current occupancy.
  always_comb begin
    kind = DEC_NONE;
    if (dec_valid) begin
      if (buf_count == '0) kind = DEC_EMPTY;
      else if (dec_accept) kind = DEC_ACCEPT;
      else                 kind = DEC_REJECT;
    end
  end

  assign take = (kind == DEC_ACCEPT) || (kind == DEC_REJECT);

  l2b_dec_spacer #(.MIN_GAP(MIN_GAP)) u_spacer (
    .clk(clk), .rst(rst), .take_i(take), .ready_o(gap_ready)
  );

  l2b_occ_counter #(.DEPTH(BUF_DEPTH), .W(BW)) u_buf_cnt (
    .clk(clk), .rst(rst), .inc_i(evt_wr), .dec_i(take),
    .cnt_o(buf_count), .ovf_o(buf_ovf_p)
  );

  l2b_occ_counter #(.DEPTH(OUT_DEPTH), .W(OW)) u_out_cnt (
    .clk(clk), .rst(rst), .inc_i(kind == DEC_ACCEPT), .dec_i(drain),
    .cnt_o(out_count), .ovf_o(out_ovf_p)
  );

  l2b_hyst_throttle #(.W(BW), .HI(BUF_HI), .LO(BUF_LO)) u_buf_thr (
    .clk(clk), .rst(rst), .cnt_i(buf_count), .thr_o(thr_buf)
  );

  l2b_hyst_throttle #(.W(OW), .HI(OUT_HI), .LO(OUT_LO)) u_out_thr (
    .clk(clk), .rst(rst), .cnt_i(out_count), .thr_o(thr_out)
  );

  assign throttle = thr_buf | thr_out;

  always_comb begin
    err_set.buf_ovf = buf_ovf_p;
    err_set.out_ovf = out_ovf_p;
    err_set.gap_err = take & ~gap_ready;
    err_set.udf_err = (kind == DEC_EMPTY);
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_q | err_set;
  end

  assign buf_ovf = err_q.buf_ovf;
  assign out_ovf = err_q.out_ovf;
  assign gap_err = err_q.gap_err;
  assign udf_err = err_q.udf_err;

endmodule

// File: rtl/l2buf_throttle_chk.sv
module l2buf_throttle_chk #(
  parameter int BUF_DEPTH = 1000,
  parameter int BUF_HI    = 990,
  parameter int OUT_DEPTH = 16,
  parameter int OUT_HI    = 14,
  parameter int BW        = 10,
  parameter int OW        = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          evt_wr,
  input logic          dec_valid,
  input logic          dec_accept,
  input logic          drain,
  input logic [BW-1:0] buf_count,
  input logic [OW-1:0] out_count,
  input logic          throttle,
  input logic          buf_ovf,
  input logic          out_ovf,
  input logic          gap_err,
  input logic          udf_err
);

  localparam logic [BW-1:0] BFULL = BW'(BUF_DEPTH);
  localparam logic [BW-1:0] BHI   = BW'(BUF_HI);
  localparam logic [OW-1:0] OFULL = OW'(OUT_DEPTH);
  localparam logic [OW-1:0] OHI   = OW'(OUT_HI);

  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (rst) buf_count <= BFULL); // R9
  AST_OUT_BOUND: assert property (@(posedge clk) disable iff (rst) out_count <= OFULL); // R10
  AST_BUF_THROTTLE: assert property (@(posedge clk) disable iff (rst) buf_count >= BHI |-> throttle); // R7
  AST_OUT_THROTTLE: assert property (@(posedge clk) disable iff (rst) out_count >= OHI |-> throttle); // R8
  AST_RETIRE_ONE: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && buf_count != '0 && !evt_wr) |=> (buf_count == $past(buf_count) - BW'(1))); // R3
  AST_EMPTY_DECISION: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && buf_count == '0 && !evt_wr) |=> (buf_count == '0 && udf_err)); // R6
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (drain && out_count == '0 && !dec_valid) |=> (out_count == '0)); // R4
  AST_BUF_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (evt_wr && buf_count == BFULL && !dec_valid) |=> (buf_ovf && buf_count == BFULL)); // R9
  AST_STICKY_BUF: assert property (@(posedge clk) disable iff (rst) buf_ovf |=> buf_ovf); // R11
  AST_STICKY_OUT: assert property (@(posedge clk) disable iff (rst) out_ovf |=> out_ovf); // R11
  AST_STICKY_GAP: assert property (@(posedge clk) disable iff (rst) gap_err |=> gap_err); // R11
  AST_STICKY_UDF: assert property (@(posedge clk) disable iff (rst) udf_err |=> udf_err); // R11

endmodule

bind l2buf_throttle l2buf_throttle_chk #(
  .BUF_DEPTH(BUF_DEPTH), .BUF_HI(BUF_HI), .OUT_DEPTH(OUT_DEPTH),
  .OUT_HI(OUT_HI), .BW(BW), .OW(OW)
) u_chk (
  .clk(clk), .rst(rst), .evt_wr(evt_wr), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .drain(drain), .buf_count(buf_count),
  .out_count(out_count), .throttle(throttle), .buf_ovf(buf_ovf),
  .out_ovf(out_ovf), .gap_err(gap_err), .udf_err(udf_err)
);

// File: tb/tb_l2buf_throttle.sv
module tb_l2buf_throttle;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_wr = 1'b0, dec_valid = 1'b0, dec_accept = 1'b0, drain = 1'b0;
  logic [9:0] buf_count;
  logic [4:0] out_count;
  logic       throttle, buf_ovf, out_ovf, gap_err, udf_err;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  l2buf_throttle dut (
    .clk(clk), .rst(rst), .evt_wr(evt_wr), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .drain(drain), .buf_count(buf_count),
    .out_count(out_count), .throttle(throttle), .buf_ovf(buf_ovf),
    .out_ovf(out_ovf), .gap_err(gap_err), .udf_err(udf_err)
  );

  // Vector: [27]wr [26]dv [25]acc [24]drn [23:16]idle [15:6]buf [5:1]out [0]thr
  localparam int NVEC = 10;
  localparam logic [27:0] VEC [NVEC] = '{
    {4'b1000, 8'd0,  10'd1, 5'd0, 1'b0},  // R2 write
    {4'b1000, 8'd0,  10'd2, 5'd0, 1'b0},  // R2 write
    {4'b1000, 8'd0,  10'd3, 5'd0, 1'b0},  // R2 write
    {4'b0110, 8'd35, 10'd2, 5'd1, 1'b0},  // R3 accept, first decision
    {4'b0100, 8'd35, 10'd1, 5'd1, 1'b0},  // R3 reject, R5 gap of 36
    {4'b1110, 8'd35, 10'd1, 5'd2, 1'b0},  // R2 write with accept
    {4'b0001, 8'd0,  10'd1, 5'd1, 1'b0},  // R4 drain
    {4'b0111, 8'd35, 10'd0, 5'd1, 1'b0},  // R3 R4 accept with drain
    {4'b0001, 8'd0,  10'd0, 5'd0, 1'b0},  // R4 drain
    {4'b0001, 8'd0,  10'd0, 5'd0, 1'b0}   // R4 drain at empty ignored
  };

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic chk_flags(input logic [3:0] exp, input string what);
    chk({buf_ovf, out_ovf, gap_err, udf_err}, exp, what);
  endtask

  // Called at a negedge; drives for one clock, returns at the next negedge.
  task automatic step(input logic w, input logic v, input logic a, input logic d);
    evt_wr = w; dec_valid = v; dec_accept = a; drain = d;
    @(negedge clk);
    evt_wr = 1'b0; dec_valid = 1'b0; dec_accept = 1'b0; drain = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(buf_count, 0, "R1 buf_count after reset");
    chk(out_count, 0, "R1 out_count after reset");
    chk(throttle, 0, "R1 throttle after reset");
    chk_flags(4'b0000, "R1 flags after reset");

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24]);
      chk(buf_count, int'(VEC[i][15:6]), $sformatf("R2/R3 vec %0d buf_count", i));
      chk(out_count, int'(VEC[i][5:1]), $sformatf("R3/R4 vec %0d out_count", i));
      chk(throttle, int'(VEC[i][0]), $sformatf("R7 vec %0d throttle", i));
      chk_flags(4'b0000, $sformatf("R5 vec %0d flags", i));
      idle(int'(VEC[i][23:16]));
    end

    // R7 and R9: event store threshold, hysteresis, overflow
    do_reset();
    for (int i = 0; i < 989; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    chk(buf_count, 989, "R2 fill to 989");
    chk(throttle, 0, "R7 throttle below 990");
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk(throttle, 1, "R7 throttle at 990");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    chk(buf_count, 1000, "R9 full count");
    chk(buf_ovf, 0, "R9 no overflow at full");
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk(buf_count, 1000, "R9 count holds on overflow");
    chk(buf_ovf, 1, "R9 overflow flagged");
    for (int i = 0; i < 18; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0);
      if (buf_count == 10'd983) chk(throttle, 1, "R7 hold at 983");
      if (buf_count == 10'd982) chk(throttle, 0, "R7 release at 982");
      idle(35);
    end
    chk(buf_count, 982, "R3 rejects retired");
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    chk(throttle, 0, "R7 off at 989 after release");
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk(throttle, 1, "R7 retrip at 990");
    chk_flags(4'b1000, "R11 overflow sticky, no others");
    do_reset();
    chk_flags(4'b0000, "R1 reset clears sticky flags");
    chk(buf_count, 0, "R1 reset clears buf_count");

    // R8 and R10: output store threshold and overflow
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 17; i++) begin
      step(1'b0, 1'b1, 1'b1, 1'b0);
      if (i == 12) chk(throttle, 0, "R8 off at out 13");
      if (i == 13) chk(throttle, 1, "R8 on at out 14");
      if (i == 15) chk(out_ovf, 0, "R10 no overflow at 16");
      idle(35);
    end
    chk(out_count, 16, "R10 out holds at 16");
    chk(buf_count, 3, "R10 event still leaves store");
    chk(out_ovf, 1, "R10 overflow flagged");
    for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
    chk(out_count, 7, "R4 drained to 7");
    chk(throttle, 1, "R8 hold at 7");
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk(throttle, 0, "R8 release at 6");

    // R5: spacing of 35 cycles flagged, decision still applied
    do_reset();
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    idle(34);
    chk(gap_err, 0, "R5 no error before second decision");
    step(1'b0, 1'b1, 1'b0, 1'b0);
    chk(gap_err, 1, "R5 early decision flagged");
    chk(buf_count, 0, "R5 early decision applied");
    chk(out_count, 1, "R5 reject leaves out_count");

    // R6: decision on empty store ignored, no timer restart
    do_reset();
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk(udf_err, 1, "R6 underflow flagged");
    chk(buf_count, 0, "R6 buf unchanged");
    chk(out_count, 0, "R6 out unchanged");
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk(out_count, 1, "R6 later accept applied");
    chk(gap_err, 0, "R6 ignored decision kept timer");

    finish_run();
  end

endmodule